// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps program order for a speculative out-of-order core. Each instruction that issues claims the free slot at the tail of a circular buffer and gets that slot's number as its tag. Execution units later broadcast their results with that tag. The buffer stores the value and marks the slot done. Slots retire one per cycle, strictly from the head. A retiring non-branch entry writes its value to the architectural register file through the commit port.

Branch entries also record, at result time, whether the prediction was wrong and the correct successor address. A correctly predicted branch retires quietly without a register write. A mispredicted branch at the head discards every entry and raises a redirect with the restart address. Tag 0 is kept free to mean "no producer", so slots are numbered 1 to DEPTH.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 1, and `commit_valid` and `flush_valid` are 0.
- R2: Accepted allocations receive tags 1, 2, ... DEPTH in turn. After DEPTH the next tag wraps to 1.
- R3: With DEPTH entries held, `alloc_ready` is 0. An `alloc_valid` request in that state is ignored, and `alloc_tag` keeps its value.
- R4: A result broadcast sets the matching entry ready and stores its value. A broadcast with tag 0, or to a slot that holds no entry, changes nothing.
- R5: Retirement happens only when the head entry is both held and ready. Results may arrive in any order, but entries retire in allocation order.
- R6: In the cycle after the head entry's result is captured, `commit_valid` is 1. For a non-branch entry `commit_wr` is also 1, and `commit_dst` and `commit_value` carry the recorded destination and captured value. The entry is freed at the next clock edge.
- R7: A branch entry whose capture reported no mispredict retires with `commit_valid` 1 and `commit_wr` 0.
- R8: A ready branch entry at the head whose capture reported a mispredict raises `flush_valid`, with `flush_target` equal to the captured target, and `commit_valid` stays 0. After the next edge the buffer is empty and `alloc_tag` is 1.
- R9: In a flush cycle, allocation and capture requests are suppressed. Entries that were already ready are also discarded.
- R10: While the buffer is full, `alloc_ready` stays 0 even in the cycle in which the head retires. It returns to 1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Request to claim the tail slot |
| alloc_opc | input | OPC_W | Opcode class of the issuing instruction |
| alloc_dst | input | REG_W | Destination register number |
| alloc_is_br | input | 1 | Issuing instruction is a branch |
| alloc_ready | output | 1 | Tail slot is free |
| alloc_tag | output | TAG_W | Tag the next accepted allocation receives |
| cap_valid | input | 1 | Result broadcast valid |
| cap_tag | input | TAG_W | Tag of the producing entry |
| cap_value | input | DATA_W | Result value |
| cap_mispred | input | 1 | Branch outcome disagreed with prediction |
| cap_target | input | ADDR_W | Correct successor address for a branch |
| commit_valid | output | 1 | Head entry retires at the next edge |
| commit_wr | output | 1 | Register file write enable |
| commit_opc | output | OPC_W | Opcode class of the retiring entry |
| commit_dst | output | REG_W | Register file write address |
| commit_value | output | DATA_W | Register file write data |
| flush_valid | output | 1 | Mispredicted branch at head; whole buffer is discarded |
| flush_target | output | ADDR_W | Restart fetch address |

## Verification
The properties assume the issue side obeys the handshake: while `alloc_ready` is low, it may raise `alloc_valid` but expects nothing to be taken. They also assume that each held tag gets at most one result broadcast before it retires. The stimulus meets both assumptions. Every allocation the scoreboard records is captured exactly once. The deliberately stray broadcasts go only to tag 0, to unheld slots, or into a flush cycle, and the one over-full request is issued while the buffer is known to be full.

// File: rtl/rob_pkg.sv
package rob_pkg;

   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_RETIRE = 2'd1,
      ACT_FLUSH  = 2'd2
   } rob_act_e;

   // Slots are numbered 1..depth; 0 is reserved for "no producer".
   function automatic int unsigned rob_wrap_next(input int unsigned cur,
                                                 input int unsigned depth);
      return (cur >= depth) ? 1 : cur + 1;
   endfunction

endpackage

// File: rtl/rob_ring_ptr.sv
module rob_ring_ptr #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [TAG_W-1:0] ptr
);
   localparam logic [TAG_W-1:0] FIRST = TAG_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= FIRST;
      else if (clear)
         ptr <= FIRST;
      else if (step)
         ptr <= TAG_W'(rob_pkg::rob_wrap_next(32'(ptr), DEPTH));
   end
endmodule

// File: rtl/rob_slot_array.sv
module rob_slot_array #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 32,
   parameter int REG_W  = 5,
   parameter int OPC_W  = 4,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_alloc,
   input  logic [TAG_W-1:0]  wr_alloc_tag,
   input  logic [OPC_W-1:0]  wr_opc,
   input  logic [REG_W-1:0]  wr_dst,
   input  logic              wr_is_br,
   input  logic              wr_cap,
   input  logic [TAG_W-1:0]  wr_cap_tag,
   input  logic [DATA_W-1:0] wr_value,
   input  logic              wr_mispred,
   input  logic [ADDR_W-1:0] wr_target,
   input  logic              wr_free,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_busy,
   output logic              rd_ready,
   output logic              rd_is_br,
   output logic              rd_mispred,
   output logic [OPC_W-1:0]  rd_opc,
   output logic [REG_W-1:0]  rd_dst,
   output logic [DATA_W-1:0] rd_value,
   output logic [ADDR_W-1:0] rd_target
);
   logic              busy_a   [DEPTH];
   logic              ready_a  [DEPTH];
   logic              br_a     [DEPTH];
   logic              mis_a    [DEPTH];
   logic [OPC_W-1:0]  opc_a    [DEPTH];
   logic [REG_W-1:0]  dst_a    [DEPTH];
   logic [DATA_W-1:0] val_a    [DEPTH];
   logic [ADDR_W-1:0] tgt_a    [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(i + 1);
      logic              busy_q, ready_q, br_q, mis_q;
      logic [OPC_W-1:0]  opc_q;
      logic [REG_W-1:0]  dst_q;
      logic [DATA_W-1:0] val_q;
      logic [ADDR_W-1:0] tgt_q;
      logic              hit_alloc, hit_cap, hit_free;

      assign hit_alloc = wr_alloc && (wr_alloc_tag == MY_TAG);
      assign hit_cap   = wr_cap   && (wr_cap_tag   == MY_TAG) && busy_q;
      assign hit_free  = wr_free  && (rd_tag       == MY_TAG);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
            br_q    <= 1'b0;
            mis_q   <= 1'b0;
            opc_q   <= '0;
            dst_q   <= '0;
            val_q   <= '0;
            tgt_q   <= '0;
         end else if (clear) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
            mis_q   <= 1'b0;
         end else if (hit_alloc) begin
            busy_q  <= 1'b1;
            ready_q <= 1'b0;
            br_q    <= wr_is_br;
            mis_q   <= 1'b0;
            opc_q   <= wr_opc;
            dst_q   <= wr_dst;
         end else if (hit_free) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
         end else if (hit_cap) begin
            ready_q <= 1'b1;
            val_q   <= wr_value;
            mis_q   <= wr_mispred;
            tgt_q   <= wr_target;
         end
      end

      assign busy_a[i]  = busy_q;
      assign ready_a[i] = ready_q;
      assign br_a[i]    = br_q;
      assign mis_a[i]   = mis_q;
      assign opc_a[i]   = opc_q;
      assign dst_a[i]   = dst_q;
      assign val_a[i]   = val_q;
      assign tgt_a[i]   = tgt_q;
   end

   always_comb begin
      rd_busy    = 1'b0;
      rd_ready   = 1'b0;
      rd_is_br   = 1'b0;
      rd_mispred = 1'b0;
      rd_opc     = '0;
      rd_dst     = '0;
      rd_value   = '0;
      rd_target  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_tag == TAG_W'(i + 1)) begin
            rd_busy    = busy_a[i];
            rd_ready   = ready_a[i];
            rd_is_br   = br_a[i];
            rd_mispred = mis_a[i];
            rd_opc     = opc_a[i];
            rd_dst     = dst_a[i];
            rd_value   = val_a[i];
            rd_target  = tgt_a[i];
         end
      end
   end
endmodule

// File: rtl/rob_retire_ctl.sv
module rob_retire_ctl (
   input  logic head_busy,
   input  logic head_ready,
   input  logic head_is_br,
   input  logic head_mispred,
   output logic retire,
   output logic write_rf,
   output logic flush
);
   import rob_pkg::*;
   rob_act_e act;

   always_comb begin
      act = ACT_IDLE;
      if (head_busy && head_ready)
         act = (head_is_br && head_mispred) ? ACT_FLUSH : ACT_RETIRE;
   end

   assign retire   = (act == ACT_RETIRE);
   assign flush    = (act == ACT_FLUSH);
   assign write_rf = retire && !head_is_br;
endmodule

// File: rtl/rob_core.sv
module rob_core #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int REG_W  = 5,
   parameter int OPC_W  = 4,
   parameter int ADDR_W = 32,
   parameter int TAG_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [OPC_W-1:0]  alloc_opc,
   input  logic [REG_W-1:0]  alloc_dst,
   input  logic              alloc_is_br,
   output logic              alloc_ready,
   output logic [TAG_W-1:0]  alloc_tag,
   input  logic              cap_valid,
   input  logic [TAG_W-1:0]  cap_tag,
   input  logic [DATA_W-1:0] cap_value,
   input  logic              cap_mispred,
   input  logic [ADDR_W-1:0] cap_target,
   output logic              commit_valid,
   output logic              commit_wr,
   output logic [OPC_W-1:0]  commit_opc,
   output logic [REG_W-1:0]  commit_dst,
   output logic [DATA_W-1:0] commit_value,
   output logic              flush_valid,
   output logic [ADDR_W-1:0] flush_target
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rob_core: DEPTH must be at least 2");
   end
   if (TAG_W < $clog2(DEPTH + 1)) begin : g_bad_tag
      $error("rob_core: TAG_W too narrow for tags 1..DEPTH");
   end
   if (DATA_W < 1 || REG_W < 1 || OPC_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("rob_core: field widths must be positive");
   end

   logic [TAG_W-1:0] head_tag;
   logic [CNT_W-1:0] count;
   logic             alloc_fire, retire, write_rf, flush;
   logic             h_busy, h_ready, h_br, h_mis;

   assign alloc_ready = (count != CNT_W'(DEPTH));
   assign alloc_fire  = alloc_valid && alloc_ready && !flush;

   rob_ring_ptr #(.DEPTH(DEPTH), .TAG_W(TAG_W)) tail_i (
      .clk(clk), .rst_n(rst_n), .clear(flush), .step(alloc_fire), .ptr(alloc_tag)
   );

   rob_ring_ptr #(.DEPTH(DEPTH), .TAG_W(TAG_W)) head_i (
      .clk(clk), .rst_n(rst_n), .clear(flush), .step(retire), .ptr(head_tag)
   );

   rob_slot_array #(
      .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W),
      .REG_W(REG_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W)
   ) slots_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (flush),
      .wr_alloc     (alloc_fire),
      .wr_alloc_tag (alloc_tag),
      .wr_opc       (alloc_opc),
      .wr_dst       (alloc_dst),
      .wr_is_br     (alloc_is_br),
      .wr_cap       (cap_valid),
      .wr_cap_tag   (cap_tag),
      .wr_value     (cap_value),
      .wr_mispred   (cap_mispred),
      .wr_target    (cap_target),
      .wr_free      (retire),
      .rd_tag       (head_tag),
      .rd_busy      (h_busy),
      .rd_ready     (h_ready),
      .rd_is_br     (h_br),
      .rd_mispred   (h_mis),
      .rd_opc       (commit_opc),
      .rd_dst       (commit_dst),
      .rd_value     (commit_value),
      .rd_target    (flush_target)
   );

   rob_retire_ctl ctl_i (
      .head_busy(h_busy), .head_ready(h_ready), .head_is_br(h_br),
      .head_mispred(h_mis), .retire(retire), .write_rf(write_rf), .flush(flush)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (flush)
         count <= '0;
      else
         count <= count + CNT_W'(alloc_fire) - CNT_W'(retire);
   end

   assign commit_valid = retire;
   assign commit_wr    = write_rf;
   assign flush_valid  = flush;
endmodule

// File: rtl/rob_core_checker.sv
module rob_core_checker #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 4,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             alloc_ready,
   input logic [TAG_W-1:0] alloc_tag,
   input logic             commit_valid,
   input logic             commit_wr,
   input logic             flush_valid,
   input logic [CNT_W-1:0] count
);
   logic accepted;
   assign accepted = alloc_valid && alloc_ready && !flush_valid;

   assert_tag_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_tag >= TAG_W'(1)) && (alloc_tag <= TAG_W'(DEPTH)));

   assert_tag_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |=> alloc_tag == (($past(alloc_tag) == TAG_W'(DEPTH)) ?
                                  TAG_W'(1) : $past(alloc_tag) + TAG_W'(1)));

   assert_full_holds_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && !alloc_ready && !flush_valid) |=> $stable(alloc_tag));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_write_needs_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_wr |-> commit_valid);

   assert_flush_excludes_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_valid && flush_valid));

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> (alloc_ready && alloc_tag == TAG_W'(1) && !commit_valid
                       && !flush_valid && count == '0));
endmodule

bind rob_core rob_core_checker #(
   .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W($clog2(DEPTH + 1))
) rob_core_checker_i (
   .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
   .alloc_tag(alloc_tag), .commit_valid(commit_valid), .commit_wr(commit_wr),
   .flush_valid(flush_valid), .count(count)
);

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int TAG_W = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_valid = 1'b0;
   logic [3:0]  alloc_opc = '0;
   logic [4:0]  alloc_dst = '0;
   logic        alloc_is_br = 1'b0;
   logic        alloc_ready;
   logic [3:0]  alloc_tag;
   logic        cap_valid = 1'b0;
   logic [3:0]  cap_tag = '0;
   logic [31:0] cap_value = '0;
   logic        cap_mispred = 1'b0;
   logic [31:0] cap_target = '0;
   logic        commit_valid, commit_wr, flush_valid;
   logic [3:0]  commit_opc;
   logic [4:0]  commit_dst;
   logic [31:0] commit_value, flush_target;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   typedef struct {
      bit          br;
      bit          mis;
      logic [4:0]  dst;
      logic [31:0] val;
      logic [31:0] tgt;
   } item_t;

   item_t exp_q[$];
   item_t pend[16];

   always #(CLK_PERIOD / 2) clk = ~clk;

   rob_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_opc(alloc_opc), .alloc_dst(alloc_dst),
      .alloc_is_br(alloc_is_br), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .cap_valid(cap_valid), .cap_tag(cap_tag), .cap_value(cap_value),
      .cap_mispred(cap_mispred), .cap_target(cap_target),
      .commit_valid(commit_valid), .commit_wr(commit_wr), .commit_opc(commit_opc),
      .commit_dst(commit_dst), .commit_value(commit_value),
      .flush_valid(flush_valid), .flush_target(flush_target)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_alloc(input logic [4:0] dst, input bit br, input logic [31:0] val,
                           input bit mis, input logic [31:0] tgt, output logic [3:0] tag);
      item_t it;
      it.br = br; it.mis = mis; it.dst = dst; it.val = val; it.tgt = tgt;
      alloc_valid = 1'b1;
      alloc_opc   = br ? 4'hB : 4'h1;
      alloc_dst   = dst;
      alloc_is_br = br;
      tag = alloc_tag;
      pend[tag] = it;
      exp_q.push_back(it);
      step();
      alloc_valid = 1'b0;
   endtask

   task automatic cap_raw(input logic [3:0] tag, input logic [31:0] val,
                          input bit mis, input logic [31:0] tgt);
      cap_valid = 1'b1; cap_tag = tag; cap_value = val;
      cap_mispred = mis; cap_target = tgt;
      step();
      cap_valid = 1'b0;
   endtask

   task automatic do_cap(input logic [3:0] tag);
      cap_raw(tag, pend[tag].val, pend[tag].mis, pend[tag].tgt);
   endtask

   // Monitor: compares every retirement or redirect against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && (commit_valid || flush_valid)) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected retirement", 1, 0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            if (flush_valid) begin
               chk(e.br && e.mis, "R8 flush only on mispredicted branch", 1, 0);
               chk(flush_target == e.tgt, "R8 flush target", flush_target, e.tgt);
               exp_q.delete();
            end else if (e.br) begin
               chk(!commit_wr, "R7 correct branch writes no register", commit_wr, 0);
            end else begin
               chk(commit_wr, "R6 write enable", commit_wr, 1);
               chk(commit_dst == e.dst, "R6 commit destination", commit_dst, e.dst);
               chk(commit_value == e.val, "R5 R6 commit value in order", commit_value, e.val);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : main
      logic [3:0] t;
      logic [3:0] tb_b;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1 reset state
      chk(alloc_ready == 1'b1, "R1 ready after reset", alloc_ready, 1);
      chk(alloc_tag == 4'd1, "R1 tag after reset", alloc_tag, 1);
      chk(!commit_valid && !flush_valid, "R1 idle outputs", commit_valid, 0);

      // R2 fill the buffer; slot 6 is a correctly predicted branch (R7)
      for (int i = 1; i <= DEPTH; i++) begin
         do_alloc(5'(i + 2), (i == 6), 32'h100 + 32'(i), 1'b0, 32'h0, t);
         chk(t == 4'(i), "R2 tag sequence", t, i);
      end
      chk(alloc_ready == 1'b0, "R3 full not ready", alloc_ready, 0);
      chk(alloc_tag == 4'd1, "R2 tag wraps to 1", alloc_tag, 1);
      alloc_valid = 1'b1;
      step();
      alloc_valid = 1'b0;
      chk(alloc_tag == 4'd1 && !alloc_ready, "R3 request while full ignored", alloc_tag, 1);

      // R4 tag 0 broadcast ignored
      cap_raw(4'd0, 32'hDEAD, 1'b0, 32'h0);
      chk(!commit_valid, "R4 tag 0 ignored", commit_valid, 0);

      // R5 out-of-order results, head not ready
      do_cap(4'd3);
      do_cap(4'd2);
      do_cap(4'd5);
      chk(!commit_valid, "R5 no retire while head not ready", commit_valid, 0);
      do_cap(4'd1);
      chk(commit_valid && !alloc_ready, "R10 full while head retires", alloc_ready, 0);
      step();
      chk(alloc_ready, "R10 ready one cycle after retire", alloc_ready, 1);
      step();
      step();
      chk(!commit_valid, "R5 stall at unready slot 4", commit_valid, 0);
      do_cap(4'd6);
      do_cap(4'd4);
      do_cap(4'd8);
      do_cap(4'd7);
      repeat (6) step();
      chk(exp_q.size() == 0, "R5 all entries retired", exp_q.size(), 0);

      // R4 broadcast to an idle slot ignored
      cap_raw(4'd1, 32'hBAD, 1'b0, 32'h0);
      do_alloc(5'd9, 1'b0, 32'h55, 1'b0, 32'h0, t);
      chk(t == 4'd1, "R2 tag after drain", t, 1);
      step();
      step();
      chk(!commit_valid, "R4 stale broadcast ignored", commit_valid, 0);
      do_cap(4'd1);
      step();
      step();

      // R8 mispredicted branch
      do_alloc(5'd10, 1'b0, 32'hA0, 1'b0, 32'h0, t);
      do_alloc(5'd0, 1'b1, 32'h0, 1'b1, 32'h400, tb_b);
      do_alloc(5'd11, 1'b0, 32'hC0, 1'b0, 32'h0, t);
      do_cap(t);
      do_cap(4'd2);
      do_cap(tb_b);
      chk(flush_valid && !commit_valid, "R8 flush raised", flush_valid, 1);
      chk(flush_target == 32'h400, "R8 target", flush_target, 32'h400);
      // R9 requests during the flush cycle
      alloc_valid = 1'b1; alloc_is_br = 1'b0; alloc_dst = 5'd12;
      cap_valid = 1'b1; cap_tag = tb_b; cap_value = 32'h77; cap_mispred = 1'b0;
      step();
      alloc_valid = 1'b0; cap_valid = 1'b0;
      chk(alloc_ready && alloc_tag == 4'd1, "R9 allocation suppressed", alloc_tag, 1);
      chk(!flush_valid && !commit_valid, "R8 empty after flush", flush_valid, 0);
      step();
      step();
      chk(!commit_valid && !flush_valid, "R9 ready entries discarded", commit_valid, 0);

      do_alloc(5'd13, 1'b0, 32'hE0, 1'b0, 32'h0, t);
      chk(t == 4'd1, "R8 restart from tag 1", t, 1);
      do_cap(t);
      repeat (3) step();
      chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule